// File: doc/BRIEF.md
# Register-Mapped Synchronous Serial Master

This block is a serial port that runs only as bus master. A small word-addressed register bus sets the frame length and the clock mode, enables the port and its interrupt causes, and moves data. Writing the data register queues a frame into an 8-entry transmit FIFO. Reading the same register takes the oldest frame from an 8-entry receive FIFO. Frames of 4 to 16 bits are shifted out most significant bit first. Every frame sent brings exactly one frame back, so software knows a transfer is finished once it has read back as many frames as it wrote.

The serial clock is not generated here. A divider elsewhere supplies a one-cycle tick, and each tick is one half-period of the serial clock. The divider settings held in this block are passed out to that divider. A loopback mode routes the outgoing bit straight back to the receive side, so the port can test itself. A frame that completes while the receive FIFO is full is dropped and latches an overrun flag. The overrun is a separate, maskable interrupt cause that is cleared by any write to the interrupt register.

Top module: `sport_master`

## Requirements
- R1: After reset, the control registers read 0, status reads 0x03 (transmit FIFO empty and not full), the interrupt register reads 0, and `irq` is low.
- R2: Word address 0 is configuration (16 bits, read back whole; bits 15:8 drive `rate_sel`). Address 1 is control (bits 6:0 kept, upper bits read 0). Address 4 is prescale (bits 7:0, drive `prescale`). Reads return the value in `bus_rdata` one cycle after the request.
- R3: Configuration bits 3:0 hold the frame length minus one. Codes 0 to 2 are treated as a 4-bit frame.
- R4: Bits go out on `mosi` most significant bit first, with two ticks per bit. `sclk` rests at configuration bit 7 (polarity). Configuration bit 6 (phase) = 0 samples on the leading edge and changes data on the trailing edge; phase = 1 does the reverse. `sclk` changes only on a tick, or when a register write changes the mode or the enable.
- R5: Control bit 3 (loopback) feeds the transmitted bit into the receiver, so each received frame equals the low bits of its transmitted frame.
- R6: A write to address 2 pushes onto the transmit FIFO and is dropped when 8 frames are already held. A read of address 2 pops the receive FIFO, and returns 0 when that FIFO is empty.
- R7: Status (address 3) has bit 0 = transmit empty, bit 1 = transmit not full, bit 2 = receive not empty, bit 3 = receive full, and bit 4 = busy. Busy is set while a frame is shifting, or while the port is enabled with transmit data waiting.
- R8: Interrupt register (address 5) reads: bit 0 = receive level of at least 4 AND control bit 0; bit 1 = transmit level of at most 4 AND control bit 1; bit 2 = overrun flag AND control bit 2. `irq` is the OR of these bits, one cycle later.
- R9: A frame that completes while the receive FIFO holds 8 frames is discarded and sets the overrun flag. Any write to address 5 clears the flag.
- R10: With control bit 4 (enable) clear, no frame shifts, `sclk` rests at the polarity level, and queued transmit frames are kept until the port is enabled.
- R11: With loopback off, received bits are taken from `miso` at the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| sclk_tick | input | 1 | Half-period tick from the divider |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Registered interrupt request |
| rate_sel | output | 8 | Serial rate field for the divider |
| prescale | output | 8 | Prescale value for the divider |

## Verification
Frames are sent in loopback under all four polarity/phase combinations, at lengths of 4, 8, 12 and 16 bits. A wire monitor rebuilds each frame from `mosi` at the sampling edges, and this catches bit-order and edge-choice errors that a loopback echo alone would hide. A run with loopback off, where the bench returns the inverted `mosi` on `miso`, tells the internal return path apart from the external one. Other patterns check the rest: frames queued while the port is disabled, nine frames pushed into an 8-deep FIFO, a short length code, and a run that overfills the receive FIFO. Together they show that the FIFOs hold and drop frames correctly, that the frame length is clamped, and how the interrupt levels and the overrun flag move as frames enter and leave.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG  = 3'd0,
    A_CTL  = 3'd1,
    A_DATA = 3'd2,
    A_STAT = 3'd3,
    A_PRE  = 3'd4,
    A_INT  = 3'd5
  } reg_addr_e;

  // control register fields
  localparam int CTL_RXIE = 0;
  localparam int CTL_TXIE = 1;
  localparam int CTL_OVIE = 2;
  localparam int CTL_LOOP = 3;
  localparam int CTL_EN   = 4;
  localparam int CTL_W    = 7;

  // configuration register fields
  localparam int CFG_PHA = 6;
  localparam int CFG_POL = 7;
endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [LW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;

  wire do_push = push && (level != LW'(DEPTH));
  wire do_pop  = pop && (level != '0);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rdata = mem[rp];
endmodule

// File: rtl/sport_shifter.sv
module sport_shifter #(
  parameter int WIDTH = 16,
  parameter int MIN_BITS = 4,
  localparam int SW = $clog2(WIDTH),
  localparam int CW = SW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [SW-1:0]    fcode,
  input  logic             loop,
  input  logic             tx_avail,
  input  logic [WIDTH-1:0] tx_data,
  input  logic             miso,
  output logic             tx_take,
  output logic             done,
  output logic [WIDTH-1:0] rx_data,
  output logic             active,
  output logic             sclk,
  output logic             mosi
);
  logic [SW-1:0]    fsz_q;
  logic             pha_q, act_q, ph_q, mosi_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] txs_q, rxs_q;

  wire [SW-1:0]    fsz_in  = (fcode < SW'(MIN_BITS - 1)) ? SW'(MIN_BITS - 1) : fcode;
  wire [WIDTH-1:0] aligned = tx_data << (SW'(WIDTH - 1) - fsz_in);
  wire [WIDTH-1:0] mask    = {WIDTH{1'b1}} >> (SW'(WIDTH - 1) - fsz_q);
  wire             lead    = ~cnt_q[0];
  wire             last    = (cnt_q == {fsz_q, 1'b1});
  wire             rx_bit  = loop ? mosi_q : miso;
  wire             smp     = pha_q ? !lead : lead;
  wire             drive   = pha_q ? lead : (!lead && !last);
  wire [WIDTH-1:0] rx_next = {rxs_q[WIDTH-2:0], rx_bit};

  assign tx_take = tick && en && !act_q && tx_avail;
  assign done    = tick && en && act_q && last;
  assign rx_data = (pha_q ? rx_next : rxs_q) & mask;
  assign active  = act_q;
  assign sclk    = ph_q ^ cpol;
  assign mosi    = mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      fsz_q  <= SW'(MIN_BITS - 1);
      pha_q  <= 1'b0;
      mosi_q <= 1'b0;
      txs_q  <= '0;
      rxs_q  <= '0;
    end else if (!en) begin
      act_q <= 1'b0;
      ph_q  <= 1'b0;
    end else if (tick) begin
      if (!act_q) begin
        if (tx_avail) begin
          act_q <= 1'b1;
          cnt_q <= '0;
          ph_q  <= 1'b0;
          fsz_q <= fsz_in;
          pha_q <= cpha;
          rxs_q <= '0;
          if (!cpha) begin
            mosi_q <= aligned[WIDTH-1];
            txs_q  <= aligned << 1;
          end else begin
            txs_q  <= aligned;
          end
        end
      end else begin
        ph_q  <= ~ph_q;
        cnt_q <= cnt_q + 1'b1;
        if (smp) rxs_q <= rx_next;
        if (drive) begin
          mosi_q <= txs_q[WIDTH-1];
          txs_q  <= txs_q << 1;
        end
        if (last) act_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sport_master.sv
module sport_master
  import sport_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int IRQ_LEVEL  = 4,
  parameter int MIN_BITS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              sclk_tick,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq,
  output logic [7:0]        rate_sel,
  output logic [7:0]        prescale
);
  localparam int LW = $clog2(FIFO_DEPTH + 1);
  localparam int SW = $clog2(REG_W);

  logic [REG_W-1:0] cfg_q;
  logic [CTL_W-1:0] ctl_q;
  logic [7:0]       pre_q;
  logic             ovr_q, irq_q;
  logic [REG_W-1:0] rd_q;

  logic [LW-1:0]    tx_lvl, rx_lvl;
  logic [REG_W-1:0] tx_head, rx_head, frame_rx;
  logic             tx_take, frame_done, sh_active;

  wire wr_en  = bus_sel && bus_wr;
  wire rd_en  = bus_sel && !bus_wr;
  wire en     = ctl_q[CTL_EN];
  wire rx_full = (rx_lvl == LW'(FIFO_DEPTH));
  wire tx_full = (tx_lvl == LW'(FIFO_DEPTH));
  wire busy   = sh_active || (en && tx_lvl != '0);

  wire [2:0] int_id = {ovr_q && ctl_q[CTL_OVIE],
                       (tx_lvl <= LW'(IRQ_LEVEL)) && ctl_q[CTL_TXIE],
                       (rx_lvl >= LW'(IRQ_LEVEL)) && ctl_q[CTL_RXIE]};
  wire [4:0] stat = {busy, rx_full, rx_lvl != '0, !tx_full, tx_lvl == '0};

  sport_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst,
    .push  (wr_en && bus_addr == A_DATA),
    .wdata (bus_wdata),
    .pop   (tx_take),
    .rdata (tx_head),
    .level (tx_lvl)
  );

  sport_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst,
    .push  (frame_done && !rx_full),
    .wdata (frame_rx),
    .pop   (rd_en && bus_addr == A_DATA),
    .rdata (rx_head),
    .level (rx_lvl)
  );

  sport_shifter #(.WIDTH(REG_W), .MIN_BITS(MIN_BITS)) u_shift (
    .clk, .rst, .en,
    .tick     (sclk_tick),
    .cpol     (cfg_q[CFG_POL]),
    .cpha     (cfg_q[CFG_PHA]),
    .fcode    (cfg_q[SW-1:0]),
    .loop     (ctl_q[CTL_LOOP]),
    .tx_avail (tx_lvl != '0),
    .tx_data  (tx_head),
    .miso,
    .tx_take,
    .done     (frame_done),
    .rx_data  (frame_rx),
    .active   (sh_active),
    .sclk,
    .mosi
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      ctl_q <= '0;
      pre_q <= '0;
      ovr_q <= 1'b0;
      irq_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      irq_q <= |int_id;
      if (wr_en) begin
        case (bus_addr)
          A_CFG:   cfg_q <= bus_wdata;
          A_CTL:   ctl_q <= bus_wdata[CTL_W-1:0];
          A_PRE:   pre_q <= bus_wdata[7:0];
          default: ;
        endcase
      end
      if (frame_done && rx_full)               ovr_q <= 1'b1;
      else if (wr_en && bus_addr == A_INT)     ovr_q <= 1'b0;
      if (rd_en) begin
        case (bus_addr)
          A_CFG:   rd_q <= cfg_q;
          A_CTL:   rd_q <= REG_W'(ctl_q);
          A_DATA:  rd_q <= (rx_lvl != '0) ? rx_head : '0;
          A_STAT:  rd_q <= REG_W'(stat);
          A_PRE:   rd_q <= REG_W'(pre_q);
          A_INT:   rd_q <= REG_W'(int_id);
          default: rd_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rd_q;
  assign irq       = irq_q;
  assign rate_sel  = cfg_q[15:8];
  assign prescale  = pre_q;
endmodule

// File: rtl/sport_master_chk.sv
module sport_master_chk #(
  parameter int FIFO_DEPTH = 8,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic          sclk_tick,
  input logic          sclk,
  input logic          irq,
  input logic          frame_done,
  input logic [LW-1:0] rx_lvl,
  input logic [LW-1:0] tx_lvl,
  input logic          ovr_q,
  input logic [2:0]    int_id
);
  wire cfg_wr  = bus_sel && bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd1);
  wire clr_wr  = bus_sel && bus_wr && bus_addr == 3'd5;
  wire pop_rd  = bus_sel && !bus_wr && bus_addr == 3'd2;
  wire drop    = frame_done && rx_lvl == LW'(FIFO_DEPTH);

  // R6
  tx_cap_chk: assert property (@(posedge clk) disable iff (rst)
    tx_lvl <= LW'(FIFO_DEPTH));

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovr_q);

  // R9
  ovr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !drop) |=> !ovr_q);

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (drop && !pop_rd) |=> rx_lvl == LW'(FIFO_DEPTH));

  // R4
  sclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sclk_tick && !cfg_wr) |=> $stable(sclk));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (int_id != 3'd0) |=> irq);
endmodule

bind sport_master sport_master_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .sclk_tick  (sclk_tick),
  .sclk       (sclk),
  .irq        (irq),
  .frame_done (frame_done),
  .rx_lvl     (rx_lvl),
  .tx_lvl     (tx_lvl),
  .ovr_q      (ovr_q),
  .int_id     (int_id)
);

// File: tb/sport_master_bench.sv
module sport_master_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sclk_tick = 1'b0;
  logic        sclk, mosi, miso, irq;
  logic [7:0]  rate_sel, prescale;

  assign miso = ~mosi;   // external partner returns the inverted bit

  sport_master u_sport_master (
    .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .sclk_tick, .sclk, .mosi, .miso, .irq, .rate_sel, .prescale
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cur_n = 8;
  logic cur_pol = 0, cur_pha = 0, cur_loop = 1;
  logic [15:0] line_q[$];
  logic [15:0] rx_q[$];
  bit done_flag = 0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fmask(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic set_cfg(input int code, input logic pol, input logic pha);
    wr_reg(3'd0, {8'h00, pol, pha, 2'b00, 4'(code)});
    cur_n = (code < 3) ? 4 : code + 1;
    cur_pol = pol; cur_pha = pha;
  endtask

  // driver: queue the frame and record what the wire and the reader should see
  task automatic send(input logic [15:0] d, input bit on_wire, input bit keep);
    wr_reg(3'd2, d);
    if (on_wire) line_q.push_back(d & fmask(cur_n));
    if (keep) rx_q.push_back((cur_loop ? d : ~d) & fmask(cur_n));
  endtask

  task automatic take(input string req);
    logic [15:0] v;
    rd_reg(3'd2, v);
    if (rx_q.size() == 0) check(req, v, 16'hxxxx);
    else check(req, v, rx_q.pop_front());
  endtask

  task automatic wait_idle;
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd_reg(3'd3, s);
      if (s[4] == 1'b0) break;
    end
    // R4: clock rests at polarity level between frames
    check("R4 idle sclk", {15'd0, sclk}, {15'd0, cur_pol});
  endtask

  // tick source: one half-period every other clock
  initial forever begin
    @(negedge clk);
    sclk_tick = ~sclk_tick;
  end

  // wire monitor: rebuild frames from mosi at sampling edges (R4)
  initial begin
    logic prev = 0;
    logic [15:0] acc = 0;
    int bits = 0;
    forever begin
      @(negedge clk);
      if (!rst && sclk !== prev && line_q.size() != 0) begin
        if ((prev == cur_pol) != cur_pha) begin
          acc = {acc[14:0], mosi};
          bits++;
          if (bits == cur_n) begin
            check("R4 wire frame", acc & fmask(cur_n), line_q.pop_front());
            bits = 0; acc = 0;
          end
        end
      end
      prev = sclk;
    end
  end

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    int codes[4] = '{3, 7, 15, 11};
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd_reg(3'd3, v); check("R1 status", v, 16'h0003);
    rd_reg(3'd1, v); check("R1 control", v, 16'h0000);
    rd_reg(3'd5, v); check("R1 int id", v, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 register readback and divider outputs
    wr_reg(3'd0, 16'hA507); rd_reg(3'd0, v); check("R2 cfg", v, 16'hA507);
    check("R2 rate_sel", {8'd0, rate_sel}, 16'h00A5);
    wr_reg(3'd4, 16'h1256); rd_reg(3'd4, v); check("R2 prescale", v, 16'h0056);
    check("R2 prescale out", {8'd0, prescale}, 16'h0056);
    wr_reg(3'd1, 16'hFFE0); rd_reg(3'd1, v); check("R2 control", v, 16'h0060);

    // R10 disabled port keeps frames
    cur_loop = 1;
    set_cfg(7, 1, 0);
    wr_reg(3'd1, 16'h0008);
    send(16'h00C3, 1, 1); send(16'h005A, 1, 1);
    repeat (40) @(negedge clk);
    rd_reg(3'd3, v); check("R10 status held", v, 16'h0002);
    check("R10 sclk idle", {15'd0, sclk}, 16'h0001);
    wr_reg(3'd1, 16'h0018);
    wait_idle();
    take("R10 first"); take("R10 second");

    // R5 R3 R4 loopback over modes and lengths
    for (int m = 0; m < 4; m++) begin
      set_cfg(codes[m], m[1], m[0]);
      send(16'hB6D9, 1, 1); send(16'h4E21, 1, 1); send(16'hFFFF, 1, 1);
      wait_idle();
      take("R5 loop a"); take("R5 loop b"); take("R3 loop c");
    end

    // R3 short code clamps to 4 bits
    set_cfg(1, 0, 0);
    send(16'h00FB, 1, 1);
    wait_idle();
    take("R3 clamp");

    // R11 external input
    cur_loop = 0;
    wr_reg(3'd1, 16'h0010);
    set_cfg(9, 0, 1); send(16'h02C5, 1, 1); wait_idle(); take("R11 ext mode1");
    set_cfg(9, 1, 0); send(16'h0137, 1, 1); wait_idle(); take("R11 ext mode2");

    // R6 R7 FIFO limits
    cur_loop = 1;
    set_cfg(7, 0, 0);
    wr_reg(3'd1, 16'h0008);
    for (int i = 0; i < 9; i++) send(16'(8'h30 + i), i < 8, i < 8);
    rd_reg(3'd3, v); check("R7 tx full", v, 16'h0000);
    wr_reg(3'd1, 16'h0018);
    wait_idle();
    rd_reg(3'd3, v); check("R7 rx full", v, 16'h000F);
    for (int i = 0; i < 8; i++) take("R6 fifo order");
    rd_reg(3'd2, v); check("R6 empty read", v, 16'h0000);

    // R8 R9 interrupts and overrun
    wr_reg(3'd1, 16'h000F);
    rd_reg(3'd5, v); check("R8 tx cause", v, 16'h0002);
    check("R8 irq high", {15'd0, irq}, 16'h0001);
    for (int i = 0; i < 5; i++) send(16'(8'h71 + i), 1, 1);
    rd_reg(3'd5, v); check("R8 no cause", v, 16'h0000);
    check("R8 irq low", {15'd0, irq}, 16'h0000);
    wr_reg(3'd1, 16'h001F);
    wait_idle();
    rd_reg(3'd5, v); check("R8 rx and tx", v, 16'h0003);
    take("R8 pop"); take("R8 pop");
    rd_reg(3'd5, v); check("R8 rx below", v, 16'h0002);
    for (int i = 0; i < 6; i++) send(16'(8'h90 + i), 1, i < 5);
    wait_idle();
    rd_reg(3'd5, v); check("R9 overrun", v, 16'h0007);
    wr_reg(3'd5, 16'h0000);
    rd_reg(3'd5, v); check("R9 cleared", v, 16'h0003);
    for (int i = 0; i < 8; i++) take("R9 kept frames");
    rd_reg(3'd2, v); check("R9 dropped frame", v, 16'h0000);

    done_flag = 1;
    finish_run();
  end
endmodule